// File: doc/BRIEF.md
# Dual Boot Region Write Lockout

This unit sits beside the program/erase sequencer of a 512 KB byte-wide flash array. It keeps two one-way lock flags, one for the bottom 16 KB of the address space and one for the top 16 KB. Each program or erase request is judged against them, and the unit returns a registered grant or deny one cycle later. When the array is in identification mode, the unit also answers status reads at two fixed addresses, so software can see whether each end region is locked.

A sector program request names its target by sector number: address bits 18:8, with 256-byte sectors. A protected region is a whole number of sectors, so a sector lies entirely inside a protected region or entirely outside it. A whole-array erase is refused as soon as either region is locked.

The flags model non-volatile state. The ordinary reset leaves them untouched. Only a test-only clear input returns them to zero.

Top module: `boot_lock_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `grant_vld` and `id_vld` read 0 after that edge. The lock flags keep their values across any `rst_n` pulse.
- R2: A `lock_lo_req` sampled high (with `rst_n` high) locks the lower region from the next cycle on. A `lock_hi_req` does the same for the upper region. Each flag is set independently of the other, and neither has to be set.
- R3: A lock flag only ever goes from 0 to 1. A repeated set request for a locked region changes nothing. Only `tst_clr` clears the flags, and it wins over a set request in the same cycle.
- R4: A sector program request (`wr_kind` = 0) whose sector number has bits 10:6 equal to 00000b (lower region) or 11111b (upper region) is denied when that region is locked. In that case `grant_vld` = 1 and `grant_ok` = 0 one cycle after the request.
- R5: A sector program request outside every locked region is granted (`grant_vld` = 1, `grant_ok` = 1). This holds at the edges: sector 040h is writable while the lower region is locked, and sector 7BFh is writable while the upper region is locked.
- R6: A whole-array erase request (`wr_kind` = 1) is granted only while both flags are clear.
- R7: One cycle after `id_rd`, `id_vld` = 1 and `id_data` reports the lock status. Address 00002h gives the lower lock and 7FFF2h gives the upper lock, as FEh when unlocked and FFh when locked. Any other address gives 00h.
- R8: Set requests sampled while `rst_n` is low have no effect. Requests presented during reset produce no valid output.
- R9: A request is judged with the flags as they stood before the edge that samples it. A set request in the same cycle as a request does not affect that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the response path |
| tst_clr | input | 1 | Test-only clear of both lock flags |
| lock_lo_req | input | 1 | Request to lock the lower region |
| lock_hi_req | input | 1 | Request to lock the upper region |
| wr_req | input | 1 | Program/erase request strobe |
| wr_kind | input | 1 | 0 = sector program, 1 = whole-array erase |
| wr_sector | input | 11 | Sector number (address bits 18:8) |
| id_rd | input | 1 | Identification-mode status read strobe |
| id_addr | input | 19 | Identification-mode read byte address |
| grant_vld | output | 1 | Decision valid, one cycle after `wr_req` |
| grant_ok | output | 1 | 1 = request permitted |
| id_vld | output | 1 | Status byte valid, one cycle after `id_rd` |
| id_data | output | 8 | Status byte |

## Verification
The assertions assume that `tst_clr` is held high through the first reset, so the flags start from a known zero. They also assume that each strobe is a single-cycle pulse and that inputs change only away from the rising edge. The stimulus drives every input on the falling edge and holds `tst_clr` during the initial reset. Its random mix biases sector numbers toward both protected regions and their neighbours, and biases identification addresses toward the two status locations. Lock and clear events are kept rare, so that long stretches run with each combination of flags.

// File: rtl/boot_lock_pkg.sv
// Shared types and constants for the dual boot region lockout unit.
package boot_lock_pkg;
    // Kind of array-modifying request under judgement.
    typedef enum logic {
        REQ_SECTOR_PGM = 1'b0,
        REQ_CHIP_ERASE = 1'b1
    } req_kind_e;

    localparam int unsigned N_REGIONS   = 2;
    localparam int unsigned REG_LO      = 0;
    localparam int unsigned REG_HI      = 1;
    localparam logic [7:0]  STAT_OPEN   = 8'hFE;
    localparam logic [7:0]  STAT_LOCKED = 8'hFF;
    localparam logic [7:0]  STAT_NONE   = 8'h00;
endpackage

// File: rtl/boot_lock_flag.sv
// One-way lock flag modelling a non-volatile bit.
// Assumes: tst_clr is asserted at least once before use so the flag is known;
// the ordinary reset does not touch the flag, it only blocks set requests.
module boot_lock_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tst_clr,
    input  logic set_req,
    output logic locked
);
    // Flag update: test clear wins, otherwise a set outside reset sticks.
    always_ff @(posedge clk) begin
        if (tst_clr)
            locked <= 1'b0;
        else if (rst_n && set_req)
            locked <= 1'b1;
    end

    // R3: the flag never drops unless the test clear was applied.
    a_r3_no_clear_without_test: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(tst_clr));

    // R2: a set request outside reset is visible on the next cycle.
    a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && !tst_clr) |=> locked);

    // R8: during reset, without a test clear, the flag holds.
    a_r8_hold_in_reset: assert property (@(posedge clk)
        (!rst_n && !tst_clr) |=> $stable(locked));
endmodule

// File: rtl/boot_region_match.sv
// Decides whether a sector number falls into one protected end region.
// Assumes: the region is aligned and a power-of-two multiple of a sector,
// so the top TAG_W sector bits identify it completely.
module boot_region_match #(
    parameter int unsigned SEC_W = 11,
    parameter int unsigned TAG_W = 5,
    parameter logic [TAG_W-1:0] TAG = '0
) (
    input  logic [SEC_W-1:0] sector,
    output logic             hit
);
    localparam int unsigned SHIFT = SEC_W - TAG_W;

    // Region compare on the upper sector bits.
    always_comb begin
        hit = ((sector >> SHIFT) == SEC_W'(TAG));
    end
endmodule

// File: rtl/boot_lock_status.sv
// Builds the identification-mode status byte from the two lock flags.
// Assumes: only the two fixed status addresses carry lock information;
// every other address answers with zero.
module boot_lock_status
    import boot_lock_pkg::*;
#(
    parameter int unsigned ADDR_W = 19,
    parameter logic [ADDR_W-1:0] LO_ADDR = '0,
    parameter logic [ADDR_W-1:0] HI_ADDR = '1
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [N_REGIONS-1:0] locks,
    output logic [7:0]           data
);
    // Address decode to the status byte.
    always_comb begin
        if (addr == LO_ADDR)
            data = locks[REG_LO] ? STAT_LOCKED : STAT_OPEN;
        else if (addr == HI_ADDR)
            data = locks[REG_HI] ? STAT_LOCKED : STAT_OPEN;
        else
            data = STAT_NONE;
    end
endmodule

// File: rtl/boot_lock_unit.sv
// Dual boot region write lockout: two one-way lock flags guarding the lowest
// and highest regions of the byte address space, a registered grant/deny for
// sector program and whole-array erase requests, and identification status.
// Assumes: strobes are single-cycle; tst_clr is used once at bring-up.
module boot_lock_unit
    import boot_lock_pkg::*;
#(
    parameter int unsigned ADDR_W   = 19,
    parameter int unsigned SECTOR_W = 8,
    parameter int unsigned REGION_W = 14
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tst_clr,
    input  logic                       lock_lo_req,
    input  logic                       lock_hi_req,
    input  logic                       wr_req,
    input  logic                       wr_kind,
    input  logic [ADDR_W-SECTOR_W-1:0] wr_sector,
    input  logic                       id_rd,
    input  logic [ADDR_W-1:0]          id_addr,
    output logic                       grant_vld,
    output logic                       grant_ok,
    output logic                       id_vld,
    output logic [7:0]                 id_data
);
    localparam int unsigned SEC_W = ADDR_W - SECTOR_W;
    localparam int unsigned TAG_W = ADDR_W - REGION_W;
    localparam logic [ADDR_W-1:0] ID_LO_ADDR = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ID_HI_ADDR = ~ADDR_W'(13);

    logic [N_REGIONS-1:0] lock_q;
    logic [N_REGIONS-1:0] sec_hit;
    logic [N_REGIONS-1:0] set_vec;
    logic [7:0]           stat_byte;
    logic                 deny;
    req_kind_e            kind;

    assign set_vec = {lock_hi_req, lock_lo_req};
    assign kind    = req_kind_e'(wr_kind);

    // One flag and one region comparator per protected end of the space.
    for (genvar g = 0; g < N_REGIONS; g++) begin : g_region
        boot_lock_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .tst_clr (tst_clr),
            .set_req (set_vec[g]),
            .locked  (lock_q[g])
        );
        boot_region_match #(
            .SEC_W (SEC_W),
            .TAG_W (TAG_W),
            .TAG   ((g == 0) ? {TAG_W{1'b0}} : {TAG_W{1'b1}})
        ) u_match (
            .sector (wr_sector),
            .hit    (sec_hit[g])
        );
    end

    boot_lock_status #(
        .ADDR_W  (ADDR_W),
        .LO_ADDR (ID_LO_ADDR),
        .HI_ADDR (ID_HI_ADDR)
    ) u_status (
        .addr  (id_addr),
        .locks (lock_q),
        .data  (stat_byte)
    );

    // Deny decision: erase needs both clear, program needs its region clear.
    always_comb begin
        if (kind == REQ_CHIP_ERASE)
            deny = |lock_q;
        else
            deny = |(lock_q & sec_hit);
    end

    // Response registers for the grant and the status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_vld <= 1'b0;
            grant_ok  <= 1'b0;
            id_vld    <= 1'b0;
            id_data   <= STAT_NONE;
        end else begin
            grant_vld <= wr_req;
            grant_ok  <= wr_req && !deny;
            id_vld    <= id_rd;
            if (id_rd)
                id_data <= stat_byte;
        end
    end

    // R1: reset leaves no valid response behind.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!grant_vld && !id_vld));

    // R4: a program into a locked region is answered with a deny.
    a_r4_locked_sector_denied: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_kind && |(lock_q & sec_hit)) |=> (grant_vld && !grant_ok));

    // R6: a whole-array erase is refused while any lock is set.
    a_r6_erase_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_kind && |lock_q) |=> !grant_ok);

    // R5: a program outside both regions is always permitted.
    a_r5_free_sector_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_kind && !(|sec_hit)) |=> (grant_vld && grant_ok));

    // R7: lower status read reflects the lower flag before the edge.
    a_r7_lo_status: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rd && id_addr == ID_LO_ADDR) |=>
            (id_vld && id_data == ($past(lock_q[REG_LO]) ? STAT_LOCKED : STAT_OPEN)));
endmodule

// File: tb/sim_boot_lock_unit.sv
module sim_boot_lock_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tst_clr = 1'b1;
    logic        lock_lo_req = 1'b0;
    logic        lock_hi_req = 1'b0;
    logic        wr_req = 1'b0;
    logic        wr_kind = 1'b0;
    logic [10:0] wr_sector = '0;
    logic        id_rd = 1'b0;
    logic [18:0] id_addr = '0;
    logic        grant_vld, grant_ok, id_vld;
    logic [7:0]  id_data;

    int checks = 0;
    int errors = 0;
    bit m_lo = 1'b0;
    bit m_hi = 1'b0;

    always #10 clk = ~clk;

    boot_lock_unit u0 (
        .clk(clk), .rst_n(rst_n), .tst_clr(tst_clr),
        .lock_lo_req(lock_lo_req), .lock_hi_req(lock_hi_req),
        .wr_req(wr_req), .wr_kind(wr_kind), .wr_sector(wr_sector),
        .id_rd(id_rd), .id_addr(id_addr),
        .grant_vld(grant_vld), .grant_ok(grant_ok),
        .id_vld(id_vld), .id_data(id_data)
    );

    function automatic bit exp_ok(bit kind, logic [10:0] sec, bit lo, bit hi);
        if (kind) return !(lo || hi);
        if (sec[10:6] == 5'h00) return !lo;
        if (sec[10:6] == 5'h1F) return !hi;
        return 1'b1;
    endfunction

    function automatic logic [7:0] exp_stat(logic [18:0] a, bit lo, bit hi);
        if (a == 19'h00002) return lo ? 8'hFF : 8'hFE;
        if (a == 19'h7FFF2) return hi ? 8'hFF : 8'hFE;
        return 8'h00;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one request cycle, then check the registered response.
    task automatic step(bit slo, bit shi, bit wr, bit kind, logic [10:0] sec,
                        bit rd, logic [18:0] addr, string tag);
        @(negedge clk);
        lock_lo_req = slo; lock_hi_req = shi;
        wr_req = wr; wr_kind = kind; wr_sector = sec;
        id_rd = rd; id_addr = addr;
        @(negedge clk);
        lock_lo_req = 0; lock_hi_req = 0; wr_req = 0; id_rd = 0;
        chk({tag, " grant_vld"}, 8'(grant_vld), 8'(wr));
        if (wr) chk({tag, " grant_ok"}, 8'(grant_ok), 8'(exp_ok(kind, sec, m_lo, m_hi)));
        chk({tag, " id_vld"}, 8'(id_vld), 8'(rd));
        if (rd) chk({tag, " id_data"}, id_data, exp_stat(addr, m_lo, m_hi));
        if (slo) m_lo = 1'b1;
        if (shi) m_hi = 1'b1;
    endtask

    task automatic test_clear();
        @(negedge clk);
        tst_clr = 1'b1; lock_lo_req = 1'b1; lock_hi_req = 1'b1;
        @(negedge clk);
        tst_clr = 1'b0; lock_lo_req = 1'b0; lock_hi_req = 1'b0;
        m_lo = 1'b0; m_hi = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 reset grant_vld", 8'(grant_vld), 8'd0);
        chk("R1 reset id_vld", 8'(id_vld), 8'd0);
        tst_clr = 1'b0; rst_n = 1'b1;

        // Unlocked state
        step(0, 0, 0, 0, 11'h000, 1, 19'h00002, "R7 lo open");
        step(0, 0, 0, 0, 11'h000, 1, 19'h7FFF2, "R7 hi open");
        step(0, 0, 0, 0, 11'h000, 1, 19'h00003, "R7 other");
        step(0, 0, 1, 1, 11'h000, 0, 19'h0, "R6 erase open");
        step(0, 0, 1, 0, 11'h000, 0, 19'h0, "R5 sector 0 open");

        // Lower lock only
        step(1, 0, 0, 0, 11'h000, 0, 19'h0, "R2 set lo");
        step(0, 0, 0, 0, 11'h000, 1, 19'h00002, "R2 lo locked");
        step(0, 0, 0, 0, 11'h000, 1, 19'h7FFF2, "R2 hi independent");
        step(0, 0, 1, 0, 11'h03F, 0, 19'h0, "R4 lo edge denied");
        step(0, 0, 1, 0, 11'h040, 0, 19'h0, "R5 lo neighbour granted");
        step(0, 0, 1, 1, 11'h000, 0, 19'h0, "R6 erase denied");

        // Set request during reset is ignored, flags persist
        @(negedge clk);
        rst_n = 1'b0; lock_hi_req = 1'b1; wr_req = 1'b1; id_rd = 1'b1;
        @(negedge clk);
        chk("R8 no grant in reset", 8'(grant_vld), 8'd0);
        chk("R8 no id in reset", 8'(id_vld), 8'd0);
        rst_n = 1'b1; lock_hi_req = 0; wr_req = 0; id_rd = 0;
        step(0, 0, 0, 0, 11'h000, 1, 19'h7FFF2, "R8 hi still open");
        step(0, 0, 0, 0, 11'h000, 1, 19'h00002, "R1 lo persists");

        // Same-cycle set and request
        step(0, 1, 1, 0, 11'h7C0, 0, 19'h0, "R9 old flag used");
        step(0, 0, 1, 0, 11'h7C0, 0, 19'h0, "R4 hi edge denied");
        step(0, 0, 1, 0, 11'h7BF, 0, 19'h0, "R5 hi neighbour granted");
        step(1, 0, 0, 0, 11'h000, 1, 19'h00002, "R3 repeat set");
        step(0, 0, 0, 0, 11'h000, 1, 19'h00002, "R3 still locked");

        // Test clear beats a simultaneous set
        test_clear();
        step(0, 0, 0, 0, 11'h000, 1, 19'h00002, "R3 clear lo");
        step(0, 0, 0, 0, 11'h000, 1, 19'h7FFF2, "R3 clear hi");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int r = int'($urandom % 100);
            bit slo = (r < 3);
            bit shi = (r >= 3 && r < 6);
            bit wr = 1'($urandom % 2);
            bit kind = ($urandom % 8) == 0;
            bit rd = 1'($urandom % 2);
            logic [10:0] sec;
            logic [18:0] addr;
            case ($urandom % 4)
                0: sec = {5'h00, 6'($urandom)};
                1: sec = {5'h1F, 6'($urandom)};
                2: sec = 11'($urandom);
                default: sec = (($urandom % 2) == 0) ? 11'h040 : 11'h7BF;
            endcase
            case ($urandom % 3)
                0: addr = 19'h00002;
                1: addr = 19'h7FFF2;
                default: addr = 19'($urandom);
            endcase
            step(slo, shi, wr, kind, sec, rd, addr, "R4 R5 R6 R7 random");
            if (i % 150 == 149) test_clear();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule